// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block holds the time of day for precision-time hardware as a seconds count and a sub-second count. On every reference clock edge it may add a programmable increment to the sub-second count. When the sub-second count passes its limit it wraps and the seconds count goes up by one. The limit is either the binary limit (2^31 counts) or one second expressed in nanoseconds (10^9 counts), chosen by a mode input.

The pace of the counter has two modes. In coarse mode the counter advances on every edge. In fine mode a 32-bit addend is added to an accumulator on every edge, and the counter advances only on the edges where that addition carries out. Software trims the frequency by reloading the addend; the nominal addend of 0x80000000 gives one advance every two edges. The time can be changed through single-cycle strobes that share one value bus. One strobe loads an absolute time. Another adds or subtracts a signed offset, and that offset changes the seconds and sub-second fields together in a single cycle. A snapshot strobe captures both fields on the same edge, so a reader always gets a consistent pair.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset, time_sec and time_nsec are 0, busy is 0, snap_sec and snap_nsec are 0, and the addend holds 0x80000000.
- R2: In coarse mode (cfg_fine=0), every edge with no command being applied adds cfg_incr to time_nsec.
- R3: With cfg_decimal=0, a sum of time_nsec and cfg_incr above 0x7FFFFFFF reduces time_nsec by 0x80000000 and adds one to time_sec.
- R4: With cfg_decimal=1, a sum at or above 1,000,000,000 reduces time_nsec by 1,000,000,000 and adds one to time_sec.
- R5: In fine mode (cfg_fine=1), addend is added modulo 2^32 to an accumulator on every edge, and the time advances only on edges where that addition carries out. An addend of 0 stops the time.
- R6: addend_wr loads addend_in as the new addend. Strobed at edge E0, the new addend is used by the accumulator from the edge after E1 onwards.
- R7: init_stb strobed at edge E0 loads val_sec/val_nsec as the time at edge E1. The time does not advance at E1.
- R8: upd_stb with upd_sign=0 adds val_sec/val_nsec to the time at edge E1. A sub-second sum at or above the active modulus wraps and carries into seconds. The time does not advance at E1.
- R9: upd_stb with upd_sign=1 subtracts val_sec/val_nsec at E1. A negative sub-second result has the active modulus added back and borrows one from seconds. Seconds wrap modulo 2^32.
- R10: A strobe accepted at E0 makes busy 1 for exactly the cycle up to E1. Strobes that arrive while busy is 1 are ignored. When several strobes arrive in one cycle, only one is taken, in the order init, then update, then addend.
- R11: snap_stb at an edge copies the time shown before that edge into snap_sec/snap_nsec. Without snap_stb, snap_sec and snap_nsec hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fine | input | 1 | 1: fine (accumulator) pacing, 0: coarse |
| cfg_decimal | input | 1 | 1: wrap at 10^9, 0: wrap at 2^31 |
| cfg_incr | input | 8 | Sub-second increment per advance |
| addend_wr | input | 1 | Strobe: reload the addend |
| addend_in | input | 32 | New addend value |
| init_stb | input | 1 | Strobe: load an absolute time |
| upd_stb | input | 1 | Strobe: apply a signed offset |
| upd_sign | input | 1 | 0 adds the offset, 1 subtracts it |
| val_sec | input | 32 | Seconds for load or offset |
| val_nsec | input | 32 | Sub-seconds for load or offset |
| snap_stb | input | 1 | Strobe: capture the time |
| busy | output | 1 | A command is pending for the next edge |
| time_sec | output | 32 | Live seconds |
| time_nsec | output | 32 | Live sub-seconds |
| snap_sec | output | 32 | Captured seconds |
| snap_nsec | output | 32 | Captured sub-seconds |

## Verification
Two events can fall on the same edge: a snapshot strobe and the edge that applies a pending offset. The bench provokes this by raising snap_stb in the busy cycle that follows an update strobe. The snapshot must return the time from before the offset, and the live time must show the offset result on that same edge. A second test puts an absolute load and an offset strobe in the same cycle. It is judged by the live time equalling the loaded value rather than the sum.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;

   typedef enum logic [1:0] {
      CMD_NONE   = 2'd0,
      CMD_LOAD   = 2'd1,
      CMD_OFFSET = 2'd2,
      CMD_RATE   = 2'd3
   } ptp_cmd_e;

endpackage

// File: rtl/ptp_rate_gen.sv
module ptp_rate_gen #(
   parameter int ACC_W    = 32,
   parameter bit HAS_FINE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fine_en,
   input  logic [ACC_W-1:0] addend,
   output logic             step
);

   generate
      if (HAS_FINE) begin : g_fine
         logic [ACC_W-1:0] acc_q;
         logic [ACC_W:0]   acc_sum;

         assign acc_sum = {1'b0, acc_q} + {1'b0, addend};
         assign step    = fine_en ? acc_sum[ACC_W] : 1'b1;

         always_ff @(posedge clk) begin
            if (!rst_n)
               acc_q <= '0;
            else if (fine_en)
               acc_q <= acc_sum[ACC_W-1:0];
         end
      end else begin : g_coarse_only
         logic unused_in;
         assign unused_in = fine_en ^ (^addend) ^ clk ^ rst_n;
         assign step      = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/ptp_tick_adder.sv
module ptp_tick_adder #(
   parameter int SUB_W = 32,
   parameter int INC_W = 8
) (
   input  logic [SUB_W-1:0] sub_i,
   input  logic [INC_W-1:0] incr_i,
   input  logic [SUB_W:0]   mod_i,
   output logic [SUB_W-1:0] sub_o,
   output logic             carry_o
);

   logic [SUB_W:0] sum;
   logic [SUB_W:0] wrapped;

   always_comb begin
      sum     = {1'b0, sub_i} + (SUB_W+1)'(incr_i);
      wrapped = sum - mod_i;
      carry_o = (sum >= mod_i);
      sub_o   = carry_o ? wrapped[SUB_W-1:0] : sum[SUB_W-1:0];
   end

endmodule

// File: rtl/ptp_offset_unit.sv
module ptp_offset_unit #(
   parameter int SEC_W = 32,
   parameter int SUB_W = 32
) (
   input  logic [SEC_W-1:0] sec_i,
   input  logic [SUB_W-1:0] sub_i,
   input  logic             neg_i,
   input  logic [SEC_W-1:0] off_sec_i,
   input  logic [SUB_W-1:0] off_sub_i,
   input  logic [SUB_W:0]   mod_i,
   output logic [SEC_W-1:0] sec_o,
   output logic [SUB_W-1:0] sub_o
);

   logic [SUB_W:0] add_raw;
   logic [SUB_W:0] add_fix;
   logic [SUB_W:0] sub_raw;
   logic [SUB_W:0] sub_fix;
   logic           carry;
   logic           borrow;

   always_comb begin
      add_raw = {1'b0, sub_i} + {1'b0, off_sub_i};
      add_fix = add_raw - mod_i;
      carry   = (add_raw >= mod_i);
      sub_raw = {1'b0, sub_i} - {1'b0, off_sub_i};
      sub_fix = sub_raw + mod_i;
      borrow  = sub_raw[SUB_W];
      if (neg_i) begin
         sub_o = borrow ? sub_fix[SUB_W-1:0] : sub_raw[SUB_W-1:0];
         sec_o = sec_i - off_sec_i - SEC_W'(borrow);
      end else begin
         sub_o = carry ? add_fix[SUB_W-1:0] : add_raw[SUB_W-1:0];
         sec_o = sec_i + off_sec_i + SEC_W'(carry);
      end
   end

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
   import ptp_time_pkg::*;
#(
   parameter int               SEC_W      = 32,
   parameter int               SUB_W      = 32,
   parameter int               INC_W      = 8,
   parameter int               ACC_W      = 32,
   parameter bit               HAS_FINE   = 1'b1,
   parameter logic [SUB_W-1:0] BIN_MAX    = 32'h7FFF_FFFF,
   parameter logic [SUB_W-1:0] DEC_MAX    = 32'd999_999_999,
   parameter logic [ACC_W-1:0] ADDEND_NOM = 32'h8000_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_fine,
   input  logic             cfg_decimal,
   input  logic [INC_W-1:0] cfg_incr,
   input  logic             addend_wr,
   input  logic [ACC_W-1:0] addend_in,
   input  logic             init_stb,
   input  logic             upd_stb,
   input  logic             upd_sign,
   input  logic [SEC_W-1:0] val_sec,
   input  logic [SUB_W-1:0] val_nsec,
   input  logic             snap_stb,
   output logic             busy,
   output logic [SEC_W-1:0] time_sec,
   output logic [SUB_W-1:0] time_nsec,
   output logic [SEC_W-1:0] snap_sec,
   output logic [SUB_W-1:0] snap_nsec
);

   localparam logic [SUB_W:0] BIN_MOD = (SUB_W+1)'(BIN_MAX) + 1'b1;
   localparam logic [SUB_W:0] DEC_MOD = (SUB_W+1)'(DEC_MAX) + 1'b1;

   initial begin
      if (INC_W > SUB_W)     $fatal(1, "increment wider than sub-second field");
      if (SUB_W < 30)        $fatal(1, "sub-second field too narrow for 10^9");
      if (ACC_W < 2)         $fatal(1, "accumulator too narrow");
      if (DEC_MAX > BIN_MAX) $fatal(1, "decimal limit above binary limit");
   end

   logic [SEC_W-1:0] sec_q;
   logic [SUB_W-1:0] sub_q;
   logic [ACC_W-1:0] addend_q;
   ptp_cmd_e         cmd_q;
   ptp_cmd_e         take_cmd;
   logic             neg_q;
   logic [SEC_W-1:0] pend_sec_q;
   logic [SUB_W-1:0] pend_sub_q;
   logic [ACC_W-1:0] pend_add_q;
   logic [SEC_W-1:0] snap_sec_q;
   logic [SUB_W-1:0] snap_sub_q;

   logic [SUB_W:0]   mod_now;
   logic             step;
   logic [SUB_W-1:0] tick_sub;
   logic             tick_carry;
   logic [SEC_W-1:0] off_sec;
   logic [SUB_W-1:0] off_sub;

   assign busy    = (cmd_q != CMD_NONE);
   assign mod_now = cfg_decimal ? DEC_MOD : BIN_MOD;

   always_comb begin
      take_cmd = CMD_NONE;
      if (!busy) begin
         if (init_stb)
            take_cmd = CMD_LOAD;
         else if (upd_stb)
            take_cmd = CMD_OFFSET;
         else if (addend_wr)
            take_cmd = CMD_RATE;
      end
   end

   ptp_rate_gen #(.ACC_W(ACC_W), .HAS_FINE(HAS_FINE)) u_rate (
      .clk     (clk),
      .rst_n   (rst_n),
      .fine_en (cfg_fine),
      .addend  (addend_q),
      .step    (step)
   );

   ptp_tick_adder #(.SUB_W(SUB_W), .INC_W(INC_W)) u_tick (
      .sub_i   (sub_q),
      .incr_i  (cfg_incr),
      .mod_i   (mod_now),
      .sub_o   (tick_sub),
      .carry_o (tick_carry)
   );

   ptp_offset_unit #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_offset (
      .sec_i     (sec_q),
      .sub_i     (sub_q),
      .neg_i     (neg_q),
      .off_sec_i (pend_sec_q),
      .off_sub_i (pend_sub_q),
      .mod_i     (mod_now),
      .sec_o     (off_sec),
      .sub_o     (off_sub)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q      <= '0;
         sub_q      <= '0;
         addend_q   <= ADDEND_NOM;
         cmd_q      <= CMD_NONE;
         neg_q      <= 1'b0;
         pend_sec_q <= '0;
         pend_sub_q <= '0;
         pend_add_q <= '0;
         snap_sec_q <= '0;
         snap_sub_q <= '0;
      end else begin
         if (snap_stb) begin
            snap_sec_q <= sec_q;
            snap_sub_q <= sub_q;
         end
         cmd_q <= take_cmd;
         if (take_cmd != CMD_NONE) begin
            neg_q      <= upd_sign;
            pend_sec_q <= val_sec;
            pend_sub_q <= val_nsec;
            pend_add_q <= addend_in;
         end
         case (cmd_q)
            CMD_LOAD: begin
               sec_q <= pend_sec_q;
               sub_q <= pend_sub_q;
            end
            CMD_OFFSET: begin
               sec_q <= off_sec;
               sub_q <= off_sub;
            end
            default: begin
               if (step) begin
                  sub_q <= tick_sub;
                  if (tick_carry)
                     sec_q <= sec_q + 1'b1;
               end
            end
         endcase
         if (cmd_q == CMD_RATE)
            addend_q <= pend_add_q;
      end
   end

   assign time_sec  = sec_q;
   assign time_nsec = sub_q;
   assign snap_sec  = snap_sec_q;
   assign snap_nsec = snap_sub_q;

endmodule

// File: rtl/ptp_time_checker.sv
module ptp_time_checker #(
   parameter int               SEC_W   = 32,
   parameter int               SUB_W   = 32,
   parameter int               INC_W   = 8,
   parameter logic [SUB_W-1:0] BIN_MAX = 32'h7FFF_FFFF,
   parameter logic [SUB_W-1:0] DEC_MAX = 32'd999_999_999
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_fine,
   input logic             cfg_decimal,
   input logic [INC_W-1:0] cfg_incr,
   input logic             addend_wr,
   input logic             init_stb,
   input logic             upd_stb,
   input logic [SEC_W-1:0] val_sec,
   input logic [SUB_W-1:0] val_nsec,
   input logic             snap_stb,
   input logic             busy,
   input logic [SEC_W-1:0] time_sec,
   input logic [SUB_W-1:0] time_nsec,
   input logic [SEC_W-1:0] snap_sec,
   input logic [SUB_W-1:0] snap_nsec
);

   localparam logic [SUB_W:0] BIN_MOD = (SUB_W+1)'(BIN_MAX) + 1'b1;
   localparam logic [SUB_W:0] DEC_MOD = (SUB_W+1)'(DEC_MAX) + 1'b1;

   logic [SUB_W:0] nxt;
   logic [SUB_W:0] mod_now;
   logic           any_stb;

   assign nxt     = {1'b0, time_nsec} + (SUB_W+1)'(cfg_incr);
   assign mod_now = cfg_decimal ? DEC_MOD : BIN_MOD;
   assign any_stb = init_stb | upd_stb | addend_wr;

   assert_coarse_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_fine && !busy && nxt < mod_now)
      |=> (time_nsec == $past(nxt[SUB_W-1:0])) && $stable(time_sec));

   assert_binary_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_fine && !busy && !cfg_decimal && nxt >= BIN_MOD && nxt < (BIN_MOD << 1))
      |=> (time_sec == $past(time_sec) + 1'b1) && ({1'b0, time_nsec} == $past(nxt) - BIN_MOD));

   assert_decimal_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_fine && !busy && cfg_decimal && nxt >= DEC_MOD && time_nsec < DEC_MAX + 1'b1)
      |=> (time_sec == $past(time_sec) + 1'b1) && ({1'b0, time_nsec} == $past(nxt) - DEC_MOD));

   assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && init_stb)
      |=> ##1 (time_sec == $past(val_sec, 2)) && (time_nsec == $past(val_nsec, 2)));

   assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && any_stb) |=> busy);

   assert_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !any_stb) |=> !busy);

   assert_snap_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
      snap_stb |=> (snap_sec == $past(time_sec)) && (snap_nsec == $past(time_nsec)));

   assert_snap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_stb |=> $stable(snap_sec) && $stable(snap_nsec));

endmodule

bind ptp_time_counter ptp_time_checker #(
   .SEC_W   (SEC_W),
   .SUB_W   (SUB_W),
   .INC_W   (INC_W),
   .BIN_MAX (BIN_MAX),
   .DEC_MAX (DEC_MAX)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_fine    (cfg_fine),
   .cfg_decimal (cfg_decimal),
   .cfg_incr    (cfg_incr),
   .addend_wr   (addend_wr),
   .init_stb    (init_stb),
   .upd_stb     (upd_stb),
   .val_sec     (val_sec),
   .val_nsec    (val_nsec),
   .snap_stb    (snap_stb),
   .busy        (busy),
   .time_sec    (time_sec),
   .time_nsec   (time_nsec),
   .snap_sec    (snap_sec),
   .snap_nsec   (snap_nsec)
);

// File: tb/tb_ptp_time_counter.sv
`timescale 1ns/1ps
module tb_ptp_time_counter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_fine = 1'b0;
   logic        cfg_decimal = 1'b0;
   logic [7:0]  cfg_incr = 8'd0;
   logic        addend_wr = 1'b0;
   logic [31:0] addend_in = '0;
   logic        init_stb = 1'b0;
   logic        upd_stb = 1'b0;
   logic        upd_sign = 1'b0;
   logic [31:0] val_sec = '0;
   logic [31:0] val_nsec = '0;
   logic        snap_stb = 1'b0;
   logic        busy;
   logic [31:0] time_sec, time_nsec, snap_sec, snap_nsec;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   ptp_time_counter dut (
      .clk(clk), .rst_n(rst_n), .cfg_fine(cfg_fine), .cfg_decimal(cfg_decimal),
      .cfg_incr(cfg_incr), .addend_wr(addend_wr), .addend_in(addend_in),
      .init_stb(init_stb), .upd_stb(upd_stb), .upd_sign(upd_sign),
      .val_sec(val_sec), .val_nsec(val_nsec), .snap_stb(snap_stb),
      .busy(busy), .time_sec(time_sec), .time_nsec(time_nsec),
      .snap_sec(snap_sec), .snap_nsec(snap_nsec)
   );

   // fields: decimal | load sec | load ns | sign | off sec | off ns | exp sec | exp ns
   localparam logic [193:0] VEC [8] = '{
      {1'b1, 32'd5,  32'd100,       1'b0, 32'd2,  32'd200,        32'd7,          32'd300},
      {1'b1, 32'd5,  32'd999999900, 1'b0, 32'd0,  32'd200,        32'd6,          32'd100},
      {1'b1, 32'd5,  32'd100,       1'b1, 32'd1,  32'd200,        32'd3,          32'd999999900},
      {1'b0, 32'd5,  32'h7FFFFFF0,  1'b0, 32'd0,  32'h20,         32'd6,          32'h10},
      {1'b0, 32'd5,  32'h10,        1'b1, 32'd0,  32'h20,         32'd4,          32'h7FFFFFF0},
      {1'b1, 32'd0,  32'd0,         1'b1, 32'd0,  32'd1,          32'hFFFFFFFF,   32'd999999999},
      {1'b1, 32'd10, 32'd500,       1'b1, 32'd10, 32'd500,        32'd0,          32'd0},
      {1'b0, 32'd1,  32'd5,         1'b0, 32'd3,  32'h7FFFFFFB,   32'd5,          32'd0}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_load(input logic [31:0] s, input logic [31:0] ns);
      init_stb = 1'b1; val_sec = s; val_nsec = ns;
      @(negedge clk);
      init_stb = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_offset(input logic neg, input logic [31:0] s, input logic [31:0] ns);
      upd_stb = 1'b1; upd_sign = neg; val_sec = s; val_nsec = ns;
      @(negedge clk);
      upd_stb = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_addend(input logic [31:0] a);
      addend_wr = 1'b1; addend_in = a;
      @(negedge clk);
      addend_wr = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] t0, s0;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state (incr 0 keeps the time still)
      chk("R1 time", {time_sec, time_nsec}, 64'd0);
      chk("R1 busy", {63'd0, busy}, 64'd0);
      chk("R1 snap", {snap_sec, snap_nsec}, 64'd0);

      // R8 / R9 vector walk with a frozen counter
      for (int i = 0; i < 8; i++) begin
         cfg_decimal = VEC[i][193];
         do_load(VEC[i][192:161], VEC[i][160:129]);
         do_offset(VEC[i][128], VEC[i][127:96], VEC[i][95:64]);
         chk(VEC[i][128] ? "R9 subtract" : "R8 add", {time_sec, time_nsec}, VEC[i][63:0]);
      end

      // R2 coarse advance; R7 load has no advance on its edge
      cfg_decimal = 1'b0; cfg_incr = 8'd10;
      do_load(32'd0, 32'd0);
      chk("R7 load exact", {time_sec, time_nsec}, 64'd0);
      step(5);
      chk("R2 coarse five steps", {time_sec, time_nsec}, {32'd0, 32'd50});

      // R4 decimal wrap
      cfg_decimal = 1'b1;
      do_load(32'd3, 32'd999999995);
      step(1);
      chk("R4 decimal wrap", {time_sec, time_nsec}, {32'd4, 32'd5});
      step(1);
      chk("R4 after wrap", {time_sec, time_nsec}, {32'd4, 32'd15});

      // R3 binary wrap
      cfg_decimal = 1'b0; cfg_incr = 8'd8;
      do_load(32'd0, 32'h7FFFFFFC);
      step(1);
      chk("R3 binary wrap", {time_sec, time_nsec}, {32'd1, 32'd4});

      // R8 offset edge replaces the tick
      cfg_decimal = 1'b1; cfg_incr = 8'd4;
      do_load(32'd0, 32'd0);
      do_offset(1'b0, 32'd0, 32'd100);
      chk("R8 offset with running count", {time_sec, time_nsec}, {32'd0, 32'd104});

      // R5 fine pacing with nominal addend: 10 advances in 20 edges
      cfg_fine = 1'b1; cfg_incr = 8'd1;
      do_load(32'd0, 32'd0);
      t0 = time_nsec;
      step(20);
      chk("R5 nominal addend", {32'd0, time_nsec - t0}, 64'd10);

      // R6 addend reload to a quarter step rate
      do_addend(32'h4000_0000);
      t0 = time_nsec;
      step(40);
      chk("R6 reloaded addend", {32'd0, time_nsec - t0}, 64'd10);

      // R5 zero addend stops the time
      do_addend(32'h0);
      t0 = time_nsec; s0 = time_sec;
      step(16);
      chk("R5 zero addend", {time_sec, time_nsec}, {s0, t0});
      do_addend(32'h8000_0000);
      cfg_fine = 1'b0;

      // R10 busy timing and strobes ignored while busy
      cfg_incr = 8'd0;
      init_stb = 1'b1; val_sec = 32'd11; val_nsec = 32'd22;
      @(negedge clk);
      chk("R10 busy raised", {63'd0, busy}, 64'd1);
      val_sec = 32'd33; val_nsec = 32'd44;
      @(negedge clk);
      init_stb = 1'b0;
      chk("R10 busy cleared", {63'd0, busy}, 64'd0);
      chk("R10 first load applied", {time_sec, time_nsec}, {32'd11, 32'd22});
      step(2);
      chk("R10 strobe during busy ignored", {time_sec, time_nsec}, {32'd11, 32'd22});

      // R11 snapshot during counting
      cfg_incr = 8'd3;
      t0 = time_nsec; s0 = time_sec;
      snap_stb = 1'b1;
      @(negedge clk);
      snap_stb = 1'b0;
      chk("R11 snapshot pair", {snap_sec, snap_nsec}, {s0, t0});
      chk("R2 live after snapshot", {time_sec, time_nsec}, {s0, t0 + 32'd3});
      step(3);
      chk("R11 snapshot held", {snap_sec, snap_nsec}, {s0, t0});

      // R11 + R8 snapshot on the offset apply edge
      cfg_incr = 8'd0;
      do_load(32'd20, 32'd0);
      upd_stb = 1'b1; upd_sign = 1'b0; val_sec = 32'd1; val_nsec = 32'd5;
      @(negedge clk);
      upd_stb = 1'b0; snap_stb = 1'b1;
      @(negedge clk);
      snap_stb = 1'b0;
      chk("R11 snapshot before offset", {snap_sec, snap_nsec}, {32'd20, 32'd0});
      chk("R8 offset same edge", {time_sec, time_nsec}, {32'd21, 32'd5});

      // R10 load wins over offset in the same cycle
      init_stb = 1'b1; upd_stb = 1'b1; val_sec = 32'd7; val_nsec = 32'd7;
      @(negedge clk);
      init_stb = 1'b0; upd_stb = 1'b0;
      @(negedge clk);
      chk("R10 load priority", {time_sec, time_nsec}, {32'd7, 32'd7});

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule